// File: doc/BRIEF.md
# Alarm Power-Off Controller

This block is a second alarm channel that sits beside a real-time clock core. Software programs a BCD date and time into six alarm registers and sets two enable bits. The block then watches the core's running time. When the time matches the alarm and both enables are set, it pulls the active-high power-enable output low, and the supply that output feeds is shut off. A sticky status flag records every match, whether or not the enables are set.

The block takes the current seconds-to-year fields and a once-per-second tick from the clock core, together with a run indication. It shares the core's write lock and busy handshake. A write lands only while the core reports the registers unlocked and not busy. The match test runs only on ticks while the clock runs. An armed alarm therefore survives a pause of the clock and fires once the clock is restarted and the time reaches it. Once the power-enable output has dropped, it stays low until reset.

Top module: `alarm_pwroff`

## Requirements
- R1: After reset, pwr_en_o is 1, alarm_flag_o is 0, and every register reads 0: the six alarm fields, the power-arm bit and the alarm-interrupt-enable bit.
- R2: The alarm fields sit at addresses 0 to 5 in the order seconds, minutes, hours, day, month, year. A write keeps only the low 7, 7, 6, 6, 5 and 8 bits of its data for those fields, and a read at the same address returns the stored value.
- R3: A write to any register takes effect only when wr_en_i=1, wr_unlocked_i=1 and busy_i=0. Otherwise the write is ignored.
- R4: In a cycle with tick_i=1 and run_i=1 in which all six alarm fields equal the current-time inputs, alarm_flag_o becomes 1 on the next cycle. A tick with run_i=0 is never a match.
- R5: pwr_en_o goes low on the cycle after a match only if bit 0 of the power-arm register (address 6) and bit 0 of the interrupt-enable register (address 7) are both 1. With either bit clear, pwr_en_o stays 1.
- R6: Once low, pwr_en_o stays low until reset, even if both enable bits are later cleared.
- R7: The flag reads back as bit 0 of address 8. An accepted write with data bit 0 = 1 clears the flag, and a write with bit 0 = 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: An armed alarm still fires after the clock is paused (run_i=0) and later restarted, once a running tick sees the matching time.
- R9: A tick on which any single field differs from its alarm field is not a match.
- R10: Addresses 6 and 7 read their bit in bit 0 with the upper bits 0. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse each second from the clock core |
| run_i | input | 1 | Clock core is running |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_day_i | input | 6 | Current day of month, BCD |
| cur_mon_i | input | 5 | Current month, BCD |
| cur_year_i | input | 8 | Current two-digit year, BCD |
| wr_unlocked_i | input | 1 | Shared write lock is open |
| busy_i | input | 1 | Clock core is busy updating |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| alarm_flag_o | output | 1 | Sticky alarm match flag |
| pwr_en_o | output | 1 | Power enable, driven low by an armed match |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that the current-time inputs are stable in the cycle in which it is sampled. They also assume that a blocked write never changes the enable state, since no other path writes it. The stimulus always drives whole-cycle values that change only at the falling edge. It steers a share of the random ticks onto the exact alarm time, so that matches, partial matches, paused ticks and writes blocked by the lock or by busy all occur often enough to be observed.

// File: rtl/alarm_pwroff_pkg.sv
package alarm_pwroff_pkg;
  localparam int NFLD   = 6;
  localparam int DW     = 8;
  localparam int A_PWR  = NFLD;
  localparam int A_IEN  = NFLD + 1;
  localparam int A_STAT = NFLD + 2;

  typedef logic [NFLD-1:0][DW-1:0] fld_arr_t;

  // keep widths per field: sec, min, hour, day, month, year
  function automatic logic [DW-1:0] fld_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7f;
      2, 3:    return 8'h3f;
      4:       return 8'h1f;
      default: return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pwroff_pkg::*;
(
  input  fld_arr_t alm_i,
  input  fld_arr_t cur_i,
  input  logic     tick_i,
  input  logic     run_i,
  output logic     hit_o
);
  logic [NFLD-1:0] eq;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign eq[g] = (alm_i[g] == (cur_i[g] & fld_mask(g)));
  end

  assign hit_o = tick_i & run_i & (&eq);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pwroff_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_unlocked_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              hit_i,
  output fld_arr_t          alm_o,
  output logic              pwr_arm_o,
  output logic              irq_en_o,
  output logic              flag_o,
  output logic [DW-1:0]     rd_data_o
);
  fld_arr_t alm_q;
  logic     pwr_arm_q, irq_en_q, flag_q;
  logic     wr_ok;

  assign wr_ok = wr_en_i & wr_unlocked_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q     <= '0;
      pwr_arm_q <= 1'b0;
      irq_en_q  <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      for (int i = 0; i < NFLD; i++) begin
        if (wr_ok && addr_i == ADDR_W'(i)) alm_q[i] <= wr_data_i & fld_mask(i);
      end
      if (wr_ok && addr_i == ADDR_W'(A_PWR)) pwr_arm_q <= wr_data_i[0];
      if (wr_ok && addr_i == ADDR_W'(A_IEN)) irq_en_q  <= wr_data_i[0];
      // a new match wins over a same-cycle clear
      if (hit_i)                                                 flag_q <= 1'b1;
      else if (wr_ok && addr_i == ADDR_W'(A_STAT) && wr_data_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (addr_i == ADDR_W'(i)) rd_data_o = alm_q[i];
    end
    if (addr_i == ADDR_W'(A_PWR))  rd_data_o = {{(DW-1){1'b0}}, pwr_arm_q};
    if (addr_i == ADDR_W'(A_IEN))  rd_data_o = {{(DW-1){1'b0}}, irq_en_q};
    if (addr_i == ADDR_W'(A_STAT)) rd_data_o = {{(DW-1){1'b0}}, flag_q};
  end

  assign alm_o     = alm_q;
  assign pwr_arm_o = pwr_arm_q;
  assign irq_en_o  = irq_en_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/alarm_pwr.sv
module alarm_pwr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic pwr_arm_i,
  input  logic irq_en_i,
  output logic pwr_en_o
);
  logic pwr_q;

  // one-way latch: only reset brings power back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pwr_q <= 1'b1;
    else if (hit_i && pwr_arm_i && irq_en_i) pwr_q <= 1'b0;
  end

  assign pwr_en_o = pwr_q;
endmodule

// File: rtl/alarm_pwroff.sv
module alarm_pwroff
  import alarm_pwroff_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [6:0]        cur_sec_i,
  input  logic [6:0]        cur_min_i,
  input  logic [5:0]        cur_hour_i,
  input  logic [5:0]        cur_day_i,
  input  logic [4:0]        cur_mon_i,
  input  logic [7:0]        cur_year_i,
  input  logic              wr_unlocked_i,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              alarm_flag_o,
  output logic              pwr_en_o
);
  fld_arr_t cur, alm;
  logic     hit, pwr_arm, irq_en;

  assign cur[0] = {1'b0, cur_sec_i};
  assign cur[1] = {1'b0, cur_min_i};
  assign cur[2] = {2'b0, cur_hour_i};
  assign cur[3] = {2'b0, cur_day_i};
  assign cur[4] = {3'b0, cur_mon_i};
  assign cur[5] = cur_year_i;

  alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_unlocked_i, .busy_i, .addr_i, .wr_data_i,
    .hit_i(hit), .alm_o(alm), .pwr_arm_o(pwr_arm), .irq_en_o(irq_en),
    .flag_o(alarm_flag_o), .rd_data_o
  );

  alarm_cmp u_cmp (
    .alm_i(alm), .cur_i(cur), .tick_i, .run_i, .hit_o(hit)
  );

  alarm_pwr u_pwr (
    .clk_i, .rst_ni, .hit_i(hit), .pwr_arm_i(pwr_arm), .irq_en_i(irq_en), .pwr_en_o
  );
endmodule

// File: rtl/alarm_pwroff_chk.sv
module alarm_pwroff_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic run_i,
  input logic wr_en_i,
  input logic wr_unlocked_i,
  input logic busy_i,
  input logic hit,
  input logic pwr_arm,
  input logic irq_en,
  input logic alarm_flag_o,
  input logic pwr_en_o
);
  p_blocked_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (!wr_unlocked_i || busy_i)) |=> ($stable(pwr_arm) && $stable(irq_en)));

  p_hit_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> alarm_flag_o);

  p_gated_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(hit && pwr_arm && irq_en));

  p_sticky_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |=> !pwr_en_o);

  p_paused_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !run_i) |-> !hit);
endmodule

bind alarm_pwroff alarm_pwroff_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .run_i, .wr_en_i, .wr_unlocked_i, .busy_i,
  .hit(hit), .pwr_arm(pwr_arm), .irq_en(irq_en), .alarm_flag_o, .pwr_en_o
);

// File: tb/alarm_pwroff_tb.sv
`timescale 1ns/1ps
module alarm_pwroff_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 0, run = 0, unl = 0, busy = 0, we = 0;
  logic [6:0] sec = 0, mnt = 0;
  logic [5:0] hr = 0, day = 0;
  logic [4:0] mon = 0;
  logic [7:0] yr = 0, wdata = 0;
  logic [3:0] addr = 0;
  logic [7:0] rd;
  logic       flag, pwr;

  int checks = 0, fails = 0;

  // model state
  logic [7:0] m_alm [6];
  logic       m_pe, m_ie, m_flag, m_pwr;

  always #5 clk = ~clk;

  alarm_pwroff u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
    .cur_sec_i(sec), .cur_min_i(mnt), .cur_hour_i(hr), .cur_day_i(day),
    .cur_mon_i(mon), .cur_year_i(yr), .wr_unlocked_i(unl), .busy_i(busy),
    .wr_en_i(we), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rd), .alarm_flag_o(flag), .pwr_en_o(pwr)
  );

  function automatic logic [7:0] msk(input int i);
    case (i) 0, 1: return 8'h7f; 2, 3: return 8'h3f; 4: return 8'h1f; default: return 8'hff; endcase
  endfunction

  function automatic logic [7:0] cur_fld(input int i);
    case (i)
      0: return {1'b0, sec}; 1: return {1'b0, mnt}; 2: return {2'b0, hr};
      3: return {2'b0, day}; 4: return {3'b0, mon}; default: return yr;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a < 6) return m_alm[a];
    case (a)
      4'd6: return {7'b0, m_pe};
      4'd7: return {7'b0, m_ie};
      4'd8: return {7'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
    m_pe = 0; m_ie = 0; m_flag = 0; m_pwr = 1;
  endtask

  task automatic model_clock();
    logic hit, ok;
    hit = tick && run;
    for (int i = 0; i < 6; i++) if (m_alm[i] != cur_fld(i)) hit = 0;
    ok = we && unl && !busy;
    if (hit && m_pe && m_ie) m_pwr = 0;
    if (hit) m_flag = 1;
    else if (ok && addr == 4'd8 && wdata[0]) m_flag = 0;
    if (ok && addr < 6) m_alm[addr] = wdata & msk(int'(addr));
    if (ok && addr == 4'd6) m_pe = wdata[0];
    if (ok && addr == 4'd7) m_ie = wdata[0];
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive after negedge, model at posedge, check at next negedge
  task automatic step(input string req, input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic u, input logic b, input logic t, input logic r);
    we = w; addr = a; wdata = d; unl = u; busy = b; tick = t; run = r;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    chk(req, "rd_data", rd, exp_rd(a));
    chk(req, "flag", {7'b0, flag}, {7'b0, m_flag});
    chk(req, "pwr_en", {7'b0, pwr}, {7'b0, m_pwr});
  endtask

  task automatic wr(input string req, input logic [3:0] a, input logic [7:0] d);
    step(req, 1, a, d, 1, 0, 0, 1);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dd, input logic [7:0] mo, input logic [7:0] y);
    sec = s[6:0]; mnt = m[6:0]; hr = h[5:0]; day = dd[5:0]; mon = mo[4:0]; yr = y;
  endtask

  task automatic arm_time();
    wr("R2", 0, 8'h56); wr("R2", 1, 8'h34); wr("R2", 2, 8'h12);
    wr("R2", 3, 8'h15); wr("R2", 4, 8'h07); wr("R2", 5, 8'h24);
  endtask

  task automatic do_reset();
    rst_n = 0; we = 0; tick = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    do_reset();

    // R1 reset state
    for (int a = 0; a < 9; a++) step("R1", 0, 4'(a), 8'h00, 1, 0, 0, 1);

    // R2 masking
    for (int a = 0; a < 6; a++) wr("R2", 4'(a), 8'hff);
    for (int a = 0; a < 6; a++) step("R2", 0, 4'(a), 8'h00, 1, 0, 0, 1);

    // R3 lock and busy
    step("R3", 1, 0, 8'h11, 0, 0, 0, 1);
    step("R3", 1, 0, 8'h22, 1, 1, 0, 1);
    step("R3", 1, 6, 8'h01, 0, 0, 0, 1);
    step("R3", 1, 7, 8'h01, 1, 1, 0, 1);
    step("R3", 0, 0, 8'h00, 1, 0, 0, 1);

    // R10 readback layout
    wr("R10", 6, 8'hff); step("R10", 0, 6, 0, 1, 0, 0, 1);
    wr("R10", 6, 8'h00);
    for (int a = 9; a < 16; a++) step("R10", 0, 4'(a), 8'h00, 1, 0, 0, 1);

    // R9 partial matches, R4 paused tick then real match
    arm_time();
    for (int f = 0; f < 6; f++) begin
      set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h07, 8'h24);
      case (f)
        0: sec = 7'h57; 1: mnt = 7'h35; 2: hr = 6'h13;
        3: day = 6'h16; 4: mon = 5'h08; default: yr = 8'h25;
      endcase
      step("R9", 0, 8, 0, 1, 0, 1, 1);
    end
    set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h07, 8'h24);
    step("R4", 0, 8, 0, 1, 0, 1, 0);
    step("R4", 0, 8, 0, 1, 0, 1, 1);
    step("R5", 0, 8, 0, 1, 0, 0, 1);

    // R7 clear semantics
    wr("R7", 8, 8'h00);
    step("R7", 1, 8, 8'h01, 0, 0, 0, 1);
    wr("R7", 8, 8'h01);
    wr("R7", 8, 8'h01);
    step("R7", 1, 8, 8'h01, 1, 0, 1, 1);

    // R5 enables one at a time, then both
    wr("R5", 8, 8'h01);
    wr("R5", 6, 8'h01);
    step("R5", 0, 8, 0, 1, 0, 1, 1);
    wr("R5", 6, 8'h00); wr("R5", 7, 8'h01);
    step("R5", 0, 8, 0, 1, 0, 1, 1);
    wr("R5", 6, 8'h01);
    step("R5", 0, 8, 0, 1, 0, 1, 1);

    // R6 sticky low
    wr("R6", 6, 8'h00); wr("R6", 7, 8'h00);
    sec = 7'h00;
    for (int i = 0; i < 4; i++) step("R6", 0, 8, 0, 1, 0, 1, 1);

    // R8 pause and restart
    do_reset();
    step("R1", 0, 8, 0, 1, 0, 0, 1);
    arm_time();
    wr("R8", 6, 8'h01); wr("R8", 7, 8'h01);
    set_time(8'h55, 8'h34, 8'h12, 8'h15, 8'h07, 8'h24);
    step("R8", 0, 8, 0, 1, 0, 1, 1);
    set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h07, 8'h24);
    for (int i = 0; i < 3; i++) step("R8", 0, 8, 0, 1, 0, 1, 0);
    step("R8", 0, 8, 0, 1, 0, 0, 1);
    step("R8", 0, 8, 0, 1, 0, 1, 1);

    // random mix
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic w, u, b, t, r;
      logic [3:0] a;
      logic [7:0] d;
      w = ($urandom % 3) == 0; u = ($urandom % 5) != 0; b = ($urandom % 5) == 0;
      t = ($urandom % 2) == 0; r = ($urandom % 6) != 0;
      a = 4'($urandom % 10);
      d = 8'($urandom);
      if (a == 4'd6 || a == 4'd7) d[0] = ($urandom % 4) == 0;
      if (($urandom % 3) == 0)
        set_time(m_alm[0], m_alm[1], m_alm[2], m_alm[3], m_alm[4], m_alm[5]);
      else if (($urandom % 2) == 0)
        set_time(m_alm[0] ^ 8'(($urandom % 2)), m_alm[1], m_alm[2], m_alm[3], m_alm[4], m_alm[5]);
      else
        set_time(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      step((t && r) ? "R4" : "R3", w, a, d, u, b, t, r);
      if (!m_pwr && ($urandom % 50) == 0) do_reset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule